// File: doc/BRIEF.md
# Mixed-Precision Multiply-Add Operand Front End

This block sits in front of a single-precision multiply-add datapath that computes a*b+c. Each of its three operands arrives as a 32-bit register word with four control bits. The operand is either used whole as a single-precision number, or one 16-bit half of the word is taken as a half-precision number and widened to single precision. Widening is exact, so every half value, subnormals included, maps to the single that has the same real value. After widening, an absolute-value flag and then a negate flag act on the sign. The three prepared operands leave the block from registers, one cycle after they are accepted.

A separate result path takes a 32-bit single-precision result and can saturate it to the unit interval [0.0, 1.0]. This path also has one cycle of registered latency. Both paths carry a valid bit and no ready signal: the block always accepts input and never applies back-pressure. A producer may present data on any cycle. When a valid bit is low, the matching outputs hold their last values and the output valid goes low one cycle later.

Top module: `mixfma_front`

## Requirements
- R1: When an operand's format bit (fmt_half[i]) is 0, its 32-bit input word is used as the single-precision operand unchanged, apart from the sign modifiers.
- R2: When fmt_half[i] is 1, sel_upper[i]=1 takes input bits [31:16] as the half value and sel_upper[i]=0 takes bits [15:0]. When fmt_half[i] is 0, sel_upper[i] has no effect.
- R3: A normal half widens exactly: the single exponent is the half exponent plus 112 and the fraction is the half fraction shifted left by 13. For example, 0x3118 gives 0x3E230000.
- R4: A subnormal half is normalised when it widens, so 0x003F gives 0x367C0000. A half zero keeps its sign, so 0x8000 gives 0x80000000.
- R5: A half with exponent 31 and zero fraction widens to a single infinity of the same sign. A half NaN widens to a single with exponent 255, bit 22 set, and bits [21:13] equal to half fraction bits [8:0].
- R6: After the format step, abs_en[i] clears bit 31 and then neg_en[i] inverts bit 31. With both set the result is -|x|. This holds for single operands, for half operands and for zeros.
- R7: The prepared operands are registered. out_valid equals in_valid one cycle earlier. When in_valid is low, the operand outputs keep their values. After reset all outputs are 0.
- R8: With clamp_en set, a result that is a NaN (exponent 255 with a nonzero fraction) or has bit 31 set becomes 0x00000000. A result at or above 1.0, including +infinity, becomes 0x3F800000. Any other result passes unchanged.
- R9: With clamp_en clear, the result passes unchanged, NaNs and negative values included.
- R10: The clamp path is registered. cl_valid equals res_valid one cycle earlier. cl_data holds its value while res_valid is low and is 0 after reset.
- R11: Control bit i acts only on operand i: bit 0 controls operand a, bit 1 operand b and bit 2 operand c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand words and controls are valid this cycle |
| opa_in | input | 32 | Register word for operand a |
| opb_in | input | 32 | Register word for operand b |
| opc_in | input | 32 | Register word for operand c |
| fmt_half | input | 3 | Per operand: 1 for a half-precision value, 0 for single precision |
| sel_upper | input | 3 | Per operand half select: 1 for the upper half, 0 for the lower half |
| abs_en | input | 3 | Per operand: clear the sign bit |
| neg_en | input | 3 | Per operand: invert the sign bit, applied after abs_en |
| out_valid | output | 1 | Prepared operands are valid |
| opa_out | output | 32 | Prepared single-precision operand a |
| opb_out | output | 32 | Prepared single-precision operand b |
| opc_out | output | 32 | Prepared single-precision operand c |
| res_valid | input | 1 | Result word is valid this cycle |
| res_data | input | 32 | Single-precision result |
| clamp_en | input | 1 | Saturate the result to [0.0, 1.0] |
| cl_valid | output | 1 | Clamped result is valid |
| cl_data | output | 32 | Clamped or passed result |

## Verification
Operand preparation and result clamping can both be active in the same cycle, since they share only the clock. The bench drives both paths from one stimulus step. Every one of the 65536 half encodings goes through operand a, and all 4096 settings of the twelve control bits go through all three operands. Throughout, random results with a random clamp enable and gaps in valid run on the clamp path. Each path has its own expected-value queue, so a result on one path cannot be taken for a result on the other, and the hold checks confirm that an idle cycle on one path does not disturb the other.

// File: rtl/mixfma_pkg.sv
package mixfma_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int NUM_OPS = 3;

  localparam int H_EXP  = 5;
  localparam int H_FRAC = 10;
  localparam int S_EXP  = 8;
  localparam int S_FRAC = 23;
  localparam int H_BIAS = (1 << (H_EXP - 1)) - 1;
  localparam int S_BIAS = (1 << (S_EXP - 1)) - 1;

  localparam int FRAC_PAD = S_FRAC - H_FRAC;
  localparam int POS_W    = $clog2(H_FRAC + 1);

  localparam logic [WORD_W-1:0] ONE_SGL = {1'b0, S_EXP'(S_BIAS), {S_FRAC{1'b0}}};

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic half_fmt;
    logic upper;
    logic mag;
    logic flip;
  } opnd_ctl_t;
endpackage

// File: rtl/half_widen.sv
module half_widen
  import mixfma_pkg::*;
(
  input  half_t h,
  output word_t w
);
  logic              sgn;
  logic [H_EXP-1:0]  hexp;
  logic [H_FRAC-1:0] hfrac;
  logic [POS_W-1:0]  lead;
  logic [POS_W-1:0]  shamt;
  logic [H_FRAC-1:0] nfrac;

  assign {sgn, hexp, hfrac} = h;

  // position of the most significant set fraction bit
  always_comb begin
    lead = '0;
    for (int k = 0; k < H_FRAC; k++) begin
      if (hfrac[k]) lead = POS_W'(k);
    end
  end

  // shifting the leading one out of the field leaves the normalised fraction
  assign shamt = POS_W'(H_FRAC) - lead;
  assign nfrac = hfrac << shamt;

  always_comb begin
    if (hexp == '1) begin
      if (hfrac == '0)
        w = {sgn, {S_EXP{1'b1}}, {S_FRAC{1'b0}}};
      else
        w = {sgn, {S_EXP{1'b1}}, 1'b1, hfrac[H_FRAC-2:0], {FRAC_PAD{1'b0}}};
    end else if (hexp == '0) begin
      if (hfrac == '0)
        w = {sgn, {(WORD_W-1){1'b0}}};
      else
        w = {sgn, S_EXP'(lead) + S_EXP'(S_BIAS - H_BIAS - H_FRAC + 1),
             nfrac, {FRAC_PAD{1'b0}}};
    end else begin
      w = {sgn, S_EXP'(hexp) + S_EXP'(S_BIAS - H_BIAS), hfrac, {FRAC_PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/opnd_prep.sv
module opnd_prep
  import mixfma_pkg::*;
(
  input  word_t     raw,
  input  opnd_ctl_t ctl,
  output word_t     prep
);
  half_t pick;
  word_t wide;
  word_t base;

  assign pick = ctl.upper ? raw[WORD_W-1 -: HALF_W] : raw[HALF_W-1:0];

  half_widen u_widen (
    .h (pick),
    .w (wide)
  );

  assign base = ctl.half_fmt ? wide : raw;

  // magnitude first, then sign flip
  always_comb begin
    prep = base;
    if (ctl.mag)  prep[WORD_W-1] = 1'b0;
    if (ctl.flip) prep[WORD_W-1] = ~prep[WORD_W-1];
  end
endmodule

// File: rtl/unit_clamp.sv
module unit_clamp
  import mixfma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  word_t din,
  input  logic  en,
  output logic  vld_o,
  output word_t dout
);
  logic  is_nan;
  logic  at_or_above_one;
  word_t sat;

  assign is_nan          = (din[WORD_W-2 -: S_EXP] == '1) && (din[S_FRAC-1:0] != '0);
  assign at_or_above_one = din[WORD_W-2:0] >= ONE_SGL[WORD_W-2:0];

  always_comb begin
    if (!en)                        sat = din;
    else if (is_nan || din[WORD_W-1]) sat = '0;
    else if (at_or_above_one)       sat = ONE_SGL;
    else                            sat = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dout  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dout <= sat;
    end
  end

  // R8
  clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && en |=> !dout[WORD_W-1] && dout <= ONE_SGL);

  // R9
  clamp_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && !en |=> dout == $past(din));

  // R10
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o && $stable(dout));
endmodule

// File: rtl/mixfma_front.sv
module mixfma_front
  import mixfma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] opa_in,
  input  logic [31:0] opb_in,
  input  logic [31:0] opc_in,
  input  logic [2:0]  fmt_half,
  input  logic [2:0]  sel_upper,
  input  logic [2:0]  abs_en,
  input  logic [2:0]  neg_en,
  output logic        out_valid,
  output logic [31:0] opa_out,
  output logic [31:0] opb_out,
  output logic [31:0] opc_out,
  input  logic        res_valid,
  input  logic [31:0] res_data,
  input  logic        clamp_en,
  output logic        cl_valid,
  output logic [31:0] cl_data
);
  logic [NUM_OPS-1:0][WORD_W-1:0] raw;
  logic [NUM_OPS-1:0][WORD_W-1:0] prep;
  logic [NUM_OPS-1:0][WORD_W-1:0] op_q;
  logic                           vld_q;

  assign raw = {opc_in, opb_in, opa_in};

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    opnd_ctl_t ctl;
    assign ctl = '{half_fmt: fmt_half[g], upper: sel_upper[g],
                   mag: abs_en[g], flip: neg_en[g]};

    opnd_prep u_prep (
      .raw  (raw[g]),
      .ctl  (ctl),
      .prep (prep[g])
    );

    // R1
    single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !fmt_half[g] && !abs_en[g] && !neg_en[g] |=> op_q[g] == $past(raw[g]));

    // R2
    half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && fmt_half[g] && !abs_en[g] && !neg_en[g]
      |=> op_q[g][WORD_W-1] == $past(sel_upper[g] ? raw[g][WORD_W-1] : raw[g][HALF_W-1]));

    // R6
    mod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && abs_en[g] |=> op_q[g][WORD_W-1] == $past(neg_en[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op_q  <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) op_q <= prep;
    end
  end

  assign out_valid = vld_q;
  assign opa_out   = op_q[0];
  assign opb_out   = op_q[1];
  assign opc_out   = op_q[2];

  // R7
  ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(op_q));

  // R7
  ops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  unit_clamp u_clamp (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (res_valid),
    .din   (res_data),
    .en    (clamp_en),
    .vld_o (cl_valid),
    .dout  (cl_data)
  );
endmodule

// File: tb/mixfma_front_tb.sv
`timescale 1ns/1ps
module mixfma_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opa_in = '0, opb_in = '0, opc_in = '0;
  logic [2:0]  fmt_half = '0, sel_upper = '0, abs_en = '0, neg_en = '0;
  logic        out_valid;
  logic [31:0] opa_out, opb_out, opc_out;
  logic        res_valid = 1'b0;
  logic [31:0] res_data = '0;
  logic        clamp_en = 1'b0;
  logic        cl_valid;
  logic [31:0] cl_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [95:0] q_ops[$];
  string       q_ops_tag[$];
  logic [31:0] q_cl[$];
  string       q_cl_tag[$];
  logic [95:0] last_ops = '0;
  logic [31:0] last_cl = '0;

  always #2.5 clk = ~clk;

  mixfma_front u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opa_in(opa_in), .opb_in(opb_in), .opc_in(opc_in),
    .fmt_half(fmt_half), .sel_upper(sel_upper), .abs_en(abs_en), .neg_en(neg_en),
    .out_valid(out_valid), .opa_out(opa_out), .opb_out(opb_out), .opc_out(opc_out),
    .res_valid(res_valid), .res_data(res_data), .clamp_en(clamp_en),
    .cl_valid(cl_valid), .cl_data(cl_data)
  );

  task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // exact widening by repeated normalisation
  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    logic s;
    int e;
    int ex;
    logic [10:0] m;
    s = h[15];
    e = int'(h[14:10]);
    m = {1'b0, h[9:0]};
    if (e == 31) begin
      if (m[9:0] == 0) return {s, 8'hFF, 23'h0};
      return {s, 8'hFF, 1'b1, m[8:0], 13'h0};
    end
    if (e == 0 && m == 0) return {s, 31'h0};
    if (e == 0) begin
      ex = -14;
      while (m[10] == 1'b0) begin
        m = m << 1;
        ex = ex - 1;
      end
    end else begin
      ex = e - 15;
      m[10] = 1'b1;
    end
    return {s, 8'(ex + 127), m[9:0], 13'h0};
  endfunction

  function automatic logic [31:0] ref_op(input logic [31:0] d, input logic fh, input logic sl,
                                         input logic ab, input logic ng);
    logic [31:0] x;
    x = fh ? ref_widen(sl ? d[31:16] : d[15:0]) : d;
    if (ab) x[31] = 1'b0;
    if (ng) x[31] = !x[31];
    return x;
  endfunction

  function automatic logic [31:0] ref_clamp(input logic [31:0] r, input logic en);
    if (!en) return r;
    if (r[30:23] == 8'hFF && r[22:0] != 0) return 32'h0;
    if (r[31]) return 32'h0;
    if (r[30:23] >= 8'd127) return 32'h3F800000;
    return r;
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input logic [2:0] fh, input logic [2:0] sl, input logic [2:0] ab,
                      input logic [2:0] ng, input string tag,
                      input logic rv, input logic [31:0] rd, input logic ce, input string ctag);
    @(negedge clk);
    in_valid = v; opa_in = a; opb_in = b; opc_in = c;
    fmt_half = fh; sel_upper = sl; abs_en = ab; neg_en = ng;
    res_valid = rv; res_data = rd; clamp_en = ce;
    if (v) begin
      q_ops.push_back({ref_op(c, fh[2], sl[2], ab[2], ng[2]),
                       ref_op(b, fh[1], sl[1], ab[1], ng[1]),
                       ref_op(a, fh[0], sl[0], ab[0], ng[0])});
      q_ops_tag.push_back(tag);
    end
    if (rv) begin
      q_cl.push_back(ref_clamp(rd, ce));
      q_cl_tag.push_back(ctag);
    end
  endtask

  // monitor: pops the scoreboard as results appear, checks hold otherwise
  initial begin
    logic [95:0] e_ops;
    logic [31:0] e_cl;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (out_valid) begin
          if (q_ops.size() == 0) chk(96'h1, 96'h0, "R7 unexpected out_valid");
          else begin
            e_ops = q_ops.pop_front();
            t = q_ops_tag.pop_front();
            chk({opc_out, opb_out, opa_out}, e_ops, t);
            last_ops = e_ops;
          end
        end else begin
          chk({opc_out, opb_out, opa_out}, last_ops, "R7 hold while idle");
        end
        if (cl_valid) begin
          if (q_cl.size() == 0) chk(96'h1, 96'h0, "R10 unexpected cl_valid");
          else begin
            e_cl = q_cl.pop_front();
            t = q_cl_tag.pop_front();
            chk({64'h0, cl_data}, {64'h0, e_cl}, t);
            last_cl = e_cl;
          end
        end else begin
          chk({64'h0, cl_data}, {64'h0, last_cl}, "R10 hold while idle");
        end
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({out_valid, cl_valid, 30'h0, opa_out, opb_out, opc_out}, 96'h0, "R7 reset outputs");
    chk({63'h0, cl_valid, cl_data}, 96'h0, "R10 reset outputs");
    @(negedge clk);
    rst_n = 1'b1;

    // directed widening cases with concurrent clamp cases
    step(1, 32'h0000_3118, 32'h0000_003F, 32'hFFFF_8000, 3'b111, 3'b000, 3'b000, 3'b000,
         "R3/R4 exact normal, subnormal, signed zero", 1, 32'hBFC00000, 1, "R8 negative to zero");
    step(1, 32'h3118_0000, 32'h003F_1234, 32'h8000_0000, 3'b111, 3'b111, 3'b000, 3'b000,
         "R2 upper half select", 1, 32'h40000000, 1, "R8 above one");
    step(1, 32'h0000_7C00, 32'h0000_FC00, 32'h0000_7C01, 3'b111, 3'b000, 3'b000, 3'b000,
         "R5 infinities and NaN", 1, 32'h7FC00000, 1, "R8 NaN to zero");
    step(1, 32'h0000_FE00, 32'h7DFF_0000, 32'h0000_0400, 3'b111, 3'b010, 3'b000, 3'b000,
         "R5 negative NaN, max normal, min normal", 1, 32'h3F000000, 1, "R8 in range passes");
    step(1, 32'h1234_5678, 32'hC000_0000, 32'h4049_0FDB, 3'b000, 3'b111, 3'b000, 3'b000,
         "R1 single pass, R2 select ignored", 1, 32'h7F800000, 1, "R8 infinity to one");
    step(0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b101, 3'b010, 3'b111, 3'b111,
         "R7 idle", 1, 32'h3F800000, 1, "R8 exactly one");
    step(1, 32'h4049_0FDB, 32'h4049_0FDB, 32'hC049_0FDB, 3'b000, 3'b000, 3'b110, 3'b101,
         "R6 single neg, abs, neg-abs", 1, 32'h80000000, 1, "R8 negative zero");
    step(1, 32'h0000_0000, 32'h0000_8000, 32'h0000_3C00, 3'b110, 3'b000, 3'b010, 3'b111,
         "R6 zero negation and half modifiers", 0, 32'h0, 0, "R10 idle");
    step(1, 32'h0, 32'h0, 32'h0, 3'b000, 3'b000, 3'b000, 3'b000,
         "R1 zero", 1, 32'hFFC00001, 0, "R9 disabled NaN passes");
    step(1, 32'hBF80_0000, 32'h0, 32'h0, 3'b000, 3'b000, 3'b000, 3'b000,
         "R1 negative single", 1, 32'hC0000000, 0, "R9 disabled negative passes");

    // every half encoding through operand a, random traffic elsewhere
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] hv;
      logic [31:0] rr;
      hv = 16'(i);
      rr = $urandom;
      if (i[3:0] == 4'd5) rr[30:23] = 8'd127;
      step(1, {hv, hv}, $urandom, $urandom,
           {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 1'b1},
           {2'($urandom), 1'(i[4])}, {2'($urandom), 1'b0}, {2'($urandom), 1'b0},
           "R3/R4/R5 exhaustive half widening",
           $urandom_range(4, 0) != 0, rr, 1'($urandom), "R8/R9 random result clamp");
    end

    // all control settings on all three operands, with idle gaps
    for (int k = 0; k < 4096; k++) begin
      logic [11:0] kc;
      kc = 12'(k);
      if ($urandom_range(3, 0) == 0)
        step(0, $urandom, $urandom, $urandom, 3'($urandom), 3'($urandom), 3'($urandom),
             3'($urandom), "R7 idle", $urandom_range(1, 0) == 1, $urandom, 1'($urandom),
             "R8/R9 clamp during operand idle");
      step(1, $urandom, $urandom, $urandom, kc[2:0], kc[5:3], kc[8:6], kc[11:9],
           "R6/R11 control combination", $urandom_range(2, 0) != 0, $urandom, 1'($urandom),
           "R10 clamp with gaps");
    end

    step(0, 32'h0, 32'h0, 32'h0, 3'b0, 3'b0, 3'b0, 3'b0, "R7 idle", 0, 32'h0, 0, "R10 idle");
    repeat (4) @(posedge clk);
    #1;
    chk({64'h0, 32'(q_ops.size() + q_cl.size())}, 96'h0, "R7/R10 all results delivered");
    finish_run();
  end
endmodule